// File: doc/BRIEF.md
# Macroblock Inter/Intra Mode Decision Unit

This unit picks the coding mode for each macroblock of a video encoder. It takes in the 256 luminance samples of the current macroblock as a stream qualified by a valid flag, and works out a simplified variance: the sum of the absolute distances between each sample and the macroblock mean. It then weighs that variance against the 14-bit matching error that the motion compensation stage supplies for the same macroblock. A low error always yields inter coding. A higher error yields inter coding only when the variance is not smaller than the error.

On top of that computed choice it applies several overrides. A periodic refresh forces one macroblock in every 61 to intra. External commands can force intra or inter. A frame-wide fast-update flag makes every macroblock intra. The fix-macroblock and skip-picture flags freeze the refresh count.

The samples go into a two-bank store. The second pass over a finished macroblock, which accumulates the deviations, can therefore run while the next macroblock streams in. A single-cycle strobe marks each result.

Top module: `mbd_mode_decide`

## Requirements
- R1: `dec_var_o` equals the sum over all 256 samples of |sample − mean|, shifted right by 2 (bits 15:2 of the 16-bit sum). The mean is the 16-bit sample sum shifted right by 8, truncated.
- R2: If no override applies and bits 13:6 of the error are below the threshold, the decision is inter (`dec_inter_o` = 1).
- R3: If no override applies and bits 13:6 of the error are at or above the threshold, the decision is inter exactly when the variance is greater than or equal to the full 14-bit error. Otherwise it is intra (`dec_inter_o` = 0).
- R4: The threshold is 3 after reset. A cycle with `thr_we_i` high loads `thr_i`. The threshold in force on the 256th sample beat applies to that macroblock.
- R5: A refresh counter counts macroblocks from 0 to 60 and then wraps. The macroblock that completes while the count is 60 is forced intra, so every 61st macroblock is intra.
- R6: A macroblock that completes with `fix_mb_i` or `skip_pic_i` high leaves the refresh count unchanged and is never forced intra by the refresh.
- R7: `force_intra_i` forces intra and overrides the refresh and the computed decision.
- R8: `force_inter_i` forces inter and overrides both `force_intra_i` and the refresh.
- R9: `fast_upd_i` forces intra and overrides every other input.
- R10: The error and all control inputs are sampled on the 256th valid beat. Idle cycles may appear between beats, and macroblocks may follow one another with no gap. Each macroblock yields exactly one single-cycle `dec_valid_o` pulse, 256 cycles after its last beat, with results in input order. After reset all outputs are 0.
- R11: A cycle with `refresh_clr_i` high sets the refresh count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Sample beat qualifier |
| pix_i | input | 8 | Luminance sample |
| err_i | input | 14 | Motion compensation error, sampled on the last beat |
| thr_we_i | input | 1 | Threshold load strobe |
| thr_i | input | 8 | Threshold load value |
| force_intra_i | input | 1 | External forced intra |
| force_inter_i | input | 1 | External forced inter |
| fix_mb_i | input | 1 | Fix-macroblock mode; freezes the refresh count |
| skip_pic_i | input | 1 | Skip-picture mode; freezes the refresh count |
| fast_upd_i | input | 1 | Fast-update frame; all macroblocks intra |
| refresh_clr_i | input | 1 | Synchronous clear of the refresh count |
| dec_valid_o | output | 1 | Decision strobe, one cycle |
| dec_inter_o | output | 1 | 1 = inter, 0 = intra |
| dec_var_o | output | 14 | Variance of the decided macroblock |

## Verification
The hardest state to reach is the refresh boundary, count 60, while other conditions are active at the same time: a frozen count, a forced-inter command, or a frame in fast update. Reaching it needs sixty ordinary macroblocks first. The stimulus clears the count and streams sixty low-error macroblocks back to back, which also exercises the overlap of the second pass with the next fill. It then holds the count at 60 with fix-macroblock and applies each override at that exact macroblock. Equality between variance and error is set up directly with a two-level macroblock whose variance is known in closed form.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  parameter int unsigned PIX_W = 8;
  parameter int unsigned LOG_N = 8;
  parameter int unsigned ERR_W = 14;
  parameter int unsigned THR_W = 8;
  localparam int unsigned SUM_W = PIX_W + LOG_N;

  typedef struct packed {
    logic [ERR_W-1:0] err;
    logic [THR_W-1:0] thr;
    logic             fast_upd;
    logic             f_intra;
    logic             f_inter;
  } mb_ctx_t;

  typedef enum logic [2:0] {
    SEL_CALC_INTER,
    SEL_CALC_INTRA,
    SEL_LOW_ERR,
    SEL_REFRESH,
    SEL_F_INTRA,
    SEL_F_INTER,
    SEL_FAST
  } sel_e;
endpackage

// File: rtl/mbd_pix_store.sv
module mbd_pix_store #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          wbank_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rbank_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 2 * (1 << AW);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[{wbank_i, waddr_i}] <= wdata_i;
  end

  assign rdata_o = mem[{rbank_i, raddr_i}];
endmodule

// File: rtl/mbd_mad_calc.sv
module mbd_mad_calc
  import mbd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_i,
  input  mb_ctx_t          ctx_i,
  output logic             fill_last_o,
  output logic             mem_we_o,
  output logic             mem_wbank_o,
  output logic [LOG_N-1:0] mem_waddr_o,
  output logic             mem_rbank_o,
  output logic [LOG_N-1:0] mem_raddr_o,
  input  logic [PIX_W-1:0] mem_rdata_i,
  output logic             p2_last_o,
  output logic [ERR_W-1:0] var_o,
  output mb_ctx_t          ctx_o
);
  logic [LOG_N-1:0] wcnt_q, rcnt_q;
  logic             wbank_q, rbank_q, p2_act_q;
  logic [SUM_W-1:0] sum_q, sum_nxt, acc_q, acc_nxt;
  logic [PIX_W-1:0] mean_q, dev;
  mb_ctx_t          ctx_q;
  logic             fill_last, p2_last;

  assign fill_last = pix_valid_i && (wcnt_q == '1);
  assign p2_last   = p2_act_q && (rcnt_q == '1);
  assign sum_nxt   = sum_q + SUM_W'(pix_i);

  // second pass: absolute deviation from the latched mean
  assign dev     = (mem_rdata_i >= mean_q) ? (mem_rdata_i - mean_q) : (mean_q - mem_rdata_i);
  assign acc_nxt = acc_q + SUM_W'(dev);

  // first pass: store samples and build the sum
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q  <= '0;
      sum_q   <= '0;
      wbank_q <= 1'b0;
      mean_q  <= '0;
      ctx_q   <= '0;
    end else if (pix_valid_i) begin
      wcnt_q <= wcnt_q + 1'b1;
      sum_q  <= fill_last ? '0 : sum_nxt;
      if (fill_last) begin
        mean_q  <= sum_nxt[SUM_W-1 -: PIX_W];
        ctx_q   <= ctx_i;
        wbank_q <= ~wbank_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcnt_q   <= '0;
      rbank_q  <= 1'b0;
      p2_act_q <= 1'b0;
      acc_q    <= '0;
    end else if (fill_last) begin
      rcnt_q   <= '0;
      rbank_q  <= wbank_q;
      p2_act_q <= 1'b1;
      acc_q    <= '0;
    end else if (p2_act_q) begin
      rcnt_q <= rcnt_q + 1'b1;
      acc_q  <= acc_nxt;
      if (p2_last) p2_act_q <= 1'b0;
    end
  end

  assign fill_last_o = fill_last;
  assign mem_we_o    = pix_valid_i;
  assign mem_wbank_o = wbank_q;
  assign mem_waddr_o = wcnt_q;
  assign mem_rbank_o = rbank_q;
  assign mem_raddr_o = rcnt_q;
  assign p2_last_o   = p2_last;
  assign var_o       = acc_nxt[SUM_W-1 -: ERR_W];
  assign ctx_o       = ctx_q;

  // R10
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_last |-> (!p2_act_q || rcnt_q == '1));

  // R10
  pass_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p2_act_q && !p2_last && !fill_last) |=> p2_act_q);
endmodule

// File: rtl/mbd_refresh.sv
module mbd_refresh #(
  parameter int unsigned PERIOD = 61
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic mb_done_i,
  input  logic hold_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic          hit_q, step;

  assign step = mb_done_i && !hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      if (clr_i)     cnt_q <= '0;
      else if (step) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      if (mb_done_i) hit_q <= step && (cnt_q == LAST);
    end
  end

  assign hit_o = hit_q;

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R6
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mb_done_i && hold_i && !clr_i) |=> ($stable(cnt_q) && !hit_q));

  // R11
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/mbd_mode_sel.sv
module mbd_mode_sel
  import mbd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eval_i,
  input  logic [ERR_W-1:0] var_i,
  input  mb_ctx_t          ctx_i,
  input  logic             refresh_i,
  output logic             valid_o,
  output logic             inter_o,
  output logic [ERR_W-1:0] var_o
);
  sel_e sel;
  logic is_inter;

  always_comb begin
    if (ctx_i.fast_upd)                         sel = SEL_FAST;
    else if (ctx_i.f_inter)                     sel = SEL_F_INTER;
    else if (ctx_i.f_intra)                     sel = SEL_F_INTRA;
    else if (refresh_i)                         sel = SEL_REFRESH;
    else if (ctx_i.err[ERR_W-1 -: THR_W] < ctx_i.thr) sel = SEL_LOW_ERR;
    else if (var_i >= ctx_i.err)                sel = SEL_CALC_INTER;
    else                                        sel = SEL_CALC_INTRA;
  end

  assign is_inter = (sel == SEL_F_INTER) || (sel == SEL_LOW_ERR) || (sel == SEL_CALC_INTER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      inter_o <= 1'b0;
      var_o   <= '0;
    end else begin
      valid_o <= eval_i;
      if (eval_i) begin
        inter_o <= is_inter;
        var_o   <= var_i;
      end
    end
  end

  // R9
  fast_intra_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && ctx_i.fast_upd) |=> (valid_o && !inter_o));

  // R8
  force_inter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !ctx_i.fast_upd && ctx_i.f_inter) |=> (valid_o && inter_o));

  // R10
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/mbd_mode_decide.sv
module mbd_mode_decide
  import mbd_pkg::*;
#(
  parameter int unsigned REFRESH_MB = 61,
  parameter int unsigned THR_RST    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic             thr_we_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             force_intra_i,
  input  logic             force_inter_i,
  input  logic             fix_mb_i,
  input  logic             skip_pic_i,
  input  logic             fast_upd_i,
  input  logic             refresh_clr_i,
  output logic             dec_valid_o,
  output logic             dec_inter_o,
  output logic [ERR_W-1:0] dec_var_o
);
  logic [THR_W-1:0] thr_q;
  mb_ctx_t          ctx_in, ctx_mb;
  logic             fill_last, p2_last, refresh_hit;
  logic             mem_we, mem_wbank, mem_rbank;
  logic [LOG_N-1:0] mem_waddr, mem_raddr;
  logic [PIX_W-1:0] mem_rdata;
  logic [ERR_W-1:0] var_calc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       thr_q <= THR_W'(THR_RST);
    else if (thr_we_i) thr_q <= thr_i;
  end

  assign ctx_in = '{err: err_i, thr: thr_q, fast_upd: fast_upd_i,
                    f_intra: force_intra_i, f_inter: force_inter_i};

  mbd_pix_store #(.DW(PIX_W), .AW(LOG_N)) u_store (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .wbank_i (mem_wbank),
    .waddr_i (mem_waddr),
    .wdata_i (pix_i),
    .rbank_i (mem_rbank),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );

  mbd_mad_calc u_mad (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pix_valid_i (pix_valid_i),
    .pix_i       (pix_i),
    .ctx_i       (ctx_in),
    .fill_last_o (fill_last),
    .mem_we_o    (mem_we),
    .mem_wbank_o (mem_wbank),
    .mem_waddr_o (mem_waddr),
    .mem_rbank_o (mem_rbank),
    .mem_raddr_o (mem_raddr),
    .mem_rdata_i (mem_rdata),
    .p2_last_o   (p2_last),
    .var_o       (var_calc),
    .ctx_o       (ctx_mb)
  );

  mbd_refresh #(.PERIOD(REFRESH_MB)) u_refresh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (refresh_clr_i),
    .mb_done_i (fill_last),
    .hold_i    (fix_mb_i | skip_pic_i),
    .hit_o     (refresh_hit)
  );

  mbd_mode_sel u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eval_i    (p2_last),
    .var_i     (var_calc),
    .ctx_i     (ctx_mb),
    .refresh_i (refresh_hit),
    .valid_o   (dec_valid_o),
    .inter_o   (dec_inter_o),
    .var_o     (dec_var_o)
  );

  // R4
  thr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !thr_we_i |=> $stable(thr_q));
endmodule

// File: tb/sim_mbd_mode_decide.sv
module sim_mbd_mode_decide;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix = '0;
  logic [13:0] err = '0;
  logic        thr_we = 1'b0;
  logic [7:0]  thr = '0;
  logic        f_intra = 1'b0, f_inter = 1'b0, fix_mb = 1'b0, skip_pic = 1'b0, fast_upd = 1'b0;
  logic        rclr = 1'b0;
  logic        dec_valid, dec_inter;
  logic [13:0] dec_var;

  always #10 clk = ~clk;

  mbd_mode_decide u0 (
    .clk_i(clk), .rst_ni(rst_n), .pix_valid_i(pix_valid), .pix_i(pix), .err_i(err),
    .thr_we_i(thr_we), .thr_i(thr), .force_intra_i(f_intra), .force_inter_i(f_inter),
    .fix_mb_i(fix_mb), .skip_pic_i(skip_pic), .fast_upd_i(fast_upd), .refresh_clr_i(rclr),
    .dec_valid_o(dec_valid), .dec_inter_o(dec_inter), .dec_var_o(dec_var)
  );

  localparam int MAXMB = 512;
  int checks = 0, failures = 0;
  int tx = 0, rx = 0;
  int m_cnt = 0;
  int m_thr = 3;
  bit done = 0;
  logic [7:0]  px [256];
  bit          exp_inter [MAXMB];
  logic [13:0] exp_var [MAXMB];
  string       exp_tag [MAXMB];
  int          exp_cyc [MAXMB];
  int          cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int var_model();
    int s = 0, m, a = 0;
    for (int i = 0; i < 256; i++) s += px[i];
    m = s >> 8;
    for (int i = 0; i < 256; i++) a += (px[i] >= m) ? px[i] - m : m - px[i];
    return a >> 2;
  endfunction

  // pattern: 0 flat(v), 1 random, 2 half 0 / half 255, 3 ramp
  task automatic fill_px(input int pat, input int v);
    for (int i = 0; i < 256; i++)
      case (pat)
        0: px[i] = 8'(v);
        1: px[i] = 8'($urandom);
        2: px[i] = (i < 128) ? 8'd0 : 8'd255;
        default: px[i] = 8'(i);
      endcase
  endtask

  task automatic send_mb(input int e, input bit fi, input bit fn, input bit fx,
                         input bit sk, input bit fu, input int gap_pct);
    int v, hit;
    bit hold;
    string tg;
    bit inter;
    v = var_model();
    hold = fx | sk;
    hit = !hold && (m_cnt == 60);
    if (!hold) m_cnt = (m_cnt == 60) ? 0 : m_cnt + 1;
    if (fu)                         begin inter = 0; tg = "R9"; end
    else if (fn)                    begin inter = 1; tg = "R8"; end
    else if (fi)                    begin inter = 0; tg = "R7"; end
    else if (hit != 0)              begin inter = 0; tg = "R5"; end
    else if ((e >> 6) < m_thr)      begin inter = 1; tg = "R2"; end
    else                            begin inter = (v >= e); tg = "R3"; end
    if (hold && !fu && !fn && !fi) tg = "R6";
    exp_inter[tx] = inter;
    exp_var[tx]   = 14'(v);
    exp_tag[tx]   = tg;
    for (int i = 0; i < 256; i++) begin
      while (($urandom % 100) < gap_pct) begin
        pix_valid = 1'b0;
        @(negedge clk);
      end
      pix_valid = 1'b1; pix = px[i]; err = 14'(e);
      f_intra = fi; f_inter = fn; fix_mb = fx; skip_pic = sk; fast_upd = fu;
      @(negedge clk);
    end
    exp_cyc[tx] = cyc;
    tx++;
    pix_valid = 1'b0; f_intra = 0; f_inter = 0; fix_mb = 0; skip_pic = 0; fast_upd = 0;
  endtask

  task automatic write_thr(input int v);
    thr_we = 1'b1; thr = 8'(v); @(negedge clk);
    thr_we = 1'b0; m_thr = v;
  endtask

  task automatic clear_cnt();
    rclr = 1'b1; @(negedge clk);
    rclr = 1'b0; m_cnt = 0;
  endtask

  task automatic drain();
    while (rx < tx) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && dec_valid) begin
      if (rx < tx) begin
        chk(dec_var == exp_var[rx], "R1 variance", int'(dec_var), int'(exp_var[rx]));
        chk(dec_inter == exp_inter[rx], exp_tag[rx], int'(dec_inter), int'(exp_inter[rx]));
        // R10 pulse arrives 256 cycles after the last beat
        chk(cyc - exp_cyc[rx] == 256, "R10 latency", cyc - exp_cyc[rx], 256);
      end else begin
        chk(1'b0, "R10 extra strobe", rx, tx);
      end
      rx++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", rx, tx);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int e, v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(dec_valid == 0, "R10 reset valid", int'(dec_valid), 0);
    chk(dec_inter == 0, "R10 reset inter", int'(dec_inter), 0);
    chk(dec_var == 0, "R10 reset var", int'(dec_var), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: flat block, zero error
    fill_px(0, 100); send_mb(0, 0, 0, 0, 0, 0, 0);
    // R3: flat block, huge error -> intra
    fill_px(0, 7); send_mb(14'h3FFF, 0, 0, 0, 0, 0, 20);
    // R3 equality: two-level block var = 8160
    fill_px(2, 0); send_mb(8160, 0, 0, 0, 0, 0, 0);
    fill_px(2, 0); send_mb(8161, 0, 0, 0, 0, 0, 0);
    fill_px(3, 0); send_mb(191, 0, 0, 0, 0, 0, 10);
    drain();
    // R4: threshold zero makes error 1 win over var 0
    write_thr(0);
    fill_px(0, 50); send_mb(1, 0, 0, 0, 0, 0, 0);
    write_thr(255);
    fill_px(0, 50); send_mb(14'h3F00, 0, 0, 0, 0, 0, 0);
    write_thr(3);
    fill_px(0, 50); send_mb(200, 0, 0, 0, 0, 0, 0);
    drain();

    // R11 + R5: clear, then 61 low-error blocks back to back
    clear_cnt();
    for (int k = 0; k < 61; k++) begin
      fill_px(1, 0); send_mb($urandom % 192, 0, 0, 0, 0, 0, 0);
    end
    drain();
    // R6: bring count to 60, then freeze with fix/skip
    for (int k = 0; k < 60; k++) begin
      fill_px(1, 0); send_mb(0, 0, 0, 0, 0, 0, 0);
    end
    fill_px(1, 0); send_mb(0, 0, 0, 1, 0, 0, 0);
    fill_px(1, 0); send_mb(0, 0, 0, 0, 1, 0, 0);
    // R8: forced inter at the refresh point
    fill_px(1, 0); send_mb(14'h3FFF, 1, 1, 0, 0, 0, 0);
    // R9 fast update beats forced inter
    fill_px(0, 9); send_mb(0, 0, 1, 0, 0, 1, 0);
    // R7 forced intra
    fill_px(0, 9); send_mb(0, 1, 0, 0, 0, 0, 0);
    drain();

    // random mix
    for (int k = 0; k < 70; k++) begin
      fill_px(1 + ($urandom % 3), 0);
      v = var_model();
      if ($urandom % 2) e = $urandom % 256;
      else begin
        e = v + int'($urandom % 9) - 4;
        if (e < 0) e = 0;
        if (e > 16383) e = 16383;
      end
      if (($urandom % 8) == 0) write_thr($urandom % 64);
      send_mb(e, ($urandom % 10) == 0, ($urandom % 10) == 0, ($urandom % 10) == 0,
              ($urandom % 10) == 0, ($urandom % 12) == 0, $urandom % 30);
    end
    drain();
    repeat (300) @(negedge clk);
    chk(rx == tx, "R10 strobe count", rx, tx);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule